// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and three counter channels of an interval timer. The host reaches each channel's counter through addresses 0, 1 and 2, and writes control words to address 3. The block turns those byte accesses into 16-bit load values, per-channel mode and BCD settings, and load strobes for the counters. On the read side, it returns live counts, latched counts or latched status bytes.

Each channel has its own byte sequencers for writes and for reads. A channel can be set to low byte only, high byte only, or low byte followed by high byte. A count latch takes a snapshot of a channel's live count, and the snapshot is held until the host has read it completely. A readback command can latch counts, status bytes or both for any subset of the channels in a single write. A latched status byte is always read before a latched count.

The counting itself happens outside this block. The counters drive their live counts and output levels back in through input ports.

Top module: `timer_host_regs`

## Requirements
- R1: After reset, every channel is set to low-then-high access, mode 3 and binary counting (BCD flag 0), with no count or status latched. A read of a channel returns its live count, low byte first.
- R2: A write to address 3 whose bits 7:6 hold a channel number 0..2 and whose bits 5:4 are nonzero is a control word. It sets that channel's access type from bits 5:4 (1 = low only, 2 = high only, 3 = low then high), its mode from bits 3:1 and its BCD flag from bit 0. The new mode and flag appear on the channel's outputs from the next cycle.
- R3: In low-only access, a data write loads the byte into bits 7:0 of the value and zero into bits 15:8. In high-only access, it loads the byte into bits 15:8 and zero into bits 7:0. The load strobe of that channel is high for exactly the one cycle after the write, and the value is valid during that cycle.
- R4: In low-then-high access, the first data write is held and produces no strobe. The second write loads the value {second byte, first byte}, and the sequence then starts again.
- R5: Unlatched reads return bits 7:0 of the live count in low-only access and bits 15:8 in high-only access. In low-then-high access they alternate between low and high byte, starting with the low byte.
- R6: A control word with bits 5:4 equal to 0 latches that channel's live count. Later reads return the snapshot: one byte for low-only or high-only access, and two bytes (low first) for low-then-high access. After that, reads return the live count again.
- R7: A count latch request for a channel whose latched count has not been fully read is ignored, and the held snapshot is not changed.
- R8: A write to address 3 with bits 7:6 equal to 3 is a readback command. Bits 1, 2 and 3 select channels 0, 1 and 2. For every selected channel, bit 5 clear requests a count latch and bit 4 clear requests a status latch.
- R9: The status byte is {output level, 0, access type, mode, BCD flag}, in bits 7, 6, 5:4, 3:1 and 0. A latched status byte is returned by the next read of its channel, ahead of any latched count, and that read clears the status latch.
- R10: A status latch request for a channel that already holds an unread status byte is ignored. The byte first latched is the one returned.
- R11: A control word resets that channel's write and read byte sequencers. Following that, the next data write is a first (low) byte and the next unlatched read returns the low byte.
- R12: A read of address 3 returns 0. A data write to one channel does not change the byte sequencers, settings or latches of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0..2 are the channel counters, 3 is the control register |
| wr_en | input | 1 | Write strobe, one cycle per byte written |
| rd_en | input | 1 | Read strobe, one cycle per byte read; rdata is valid in the same cycle |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte; 0 when no read is active |
| live_cnt | input | 48 | Live 16-bit count of each channel, with channel c at bits 16c+15:16c |
| out_lvl | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle load strobe for each channel |
| ld_val | output | 48 | 16-bit load value of each channel, valid while its strobe is high |
| mode_o | output | 9 | 3-bit mode of each channel, with channel c at bits 3c+2:3c |
| bcd_o | output | 3 | BCD flag of each channel |

## Verification
The main sweep writes a control word for every combination of channel, access type, mode and BCD flag. Each combination is followed by a status readback and by unlatched reads. This sweep separates the field positions of both the control word and the status byte, and it catches any setting that leaks to another channel. Load writes use bytes with only the low bit set, only the high bit set, all bits set and a mixed pattern, so that swapped or misplaced byte halves show up in the value. Count latches are checked by changing the live count after the latch and then making a second latch request, which separates a held snapshot from a live value and from a re-latched one. Readback commands that select two of the three channels, status-plus-count requests and repeated status requests show the read priority order and the latch-once rule. The bench also rewrites a control word in the middle of a byte sequence to show that both sequencers restart.

// File: rtl/timer_regs_pkg.sv
package timer_regs_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  // Access type; ACC_NONE doubles as "latch command" in a control word
  // and as "nothing latched" in the count-latch state.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LOHI = 2'd3
  } acc_e;

  function automatic logic [CNT_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] val,
                                                  input logic upper);
    return upper ? val[CNT_W-1:BYTE_W] : val[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic out,
                                                    input acc_e acc,
                                                    input logic [MODE_W-1:0] mode,
                                                    input logic bcd);
    return {out, 1'b0, acc, mode, bcd};
  endfunction

endpackage

// File: rtl/tr_cmd_decode.sv
module tr_cmd_decode
  import timer_regs_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [N_CH-1:0]   ctl_set,
  output logic [N_CH-1:0]   cnt_req,
  output logic [N_CH-1:0]   sts_req,
  output logic [N_CH-1:0]   data_wr,
  output logic [N_CH-1:0]   data_rd
);

  logic       ctl_cycle;
  logic [1:0] ctl_chan;
  logic       rb_cycle;
  logic       ctl_is_latch;

  assign ctl_cycle    = wr_en && (addr == 2'd3);
  assign ctl_chan     = wdata[7:6];
  assign rb_cycle     = ctl_cycle && (ctl_chan == 2'd3);
  assign ctl_is_latch = (wdata[5:4] == ACC_NONE);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [1:0] CI = 2'(c);
    logic hit;
    logic rb_pick;
    assign hit        = ctl_cycle && (ctl_chan == CI);
    assign rb_pick    = rb_cycle && wdata[c+1];
    assign ctl_set[c] = hit && !ctl_is_latch;
    assign cnt_req[c] = (hit && ctl_is_latch) || (rb_pick && !wdata[5]);
    assign sts_req[c] = rb_pick && !wdata[4];
    assign data_wr[c] = wr_en && (addr == CI);
    assign data_rd[c] = rd_en && (addr == CI);
  end

  // R12: a data access reaches at most one channel
  p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_wr) && $onehot0(data_rd));

endmodule

// File: rtl/tr_chan_port.sv
module tr_chan_port
  import timer_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_set,
  input  logic              cnt_req,
  input  logic              sts_req,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);

  acc_e              acc;
  logic              wr_upper;   // next LOHI write is the high byte
  logic              rd_upper;   // next LOHI live read is the high byte
  logic [BYTE_W-1:0] wr_hold;
  acc_e              lat_st;     // ACC_NONE = no count held
  logic [CNT_W-1:0]  lat_val;
  logic              sts_full;
  logic [BYTE_W-1:0] sts_val;

  // named internal events
  logic cnt_take;
  logic sts_take;
  logic lohi_first;

  assign cnt_take   = cnt_req && (lat_st == ACC_NONE);
  assign sts_take   = sts_req && !sts_full;
  assign lohi_first = data_wr && (acc == ACC_LOHI) && !wr_upper;

  always_comb begin
    if (sts_full) begin
      rd_byte = sts_val;
    end else if (lat_st != ACC_NONE) begin
      rd_byte = pick_byte(lat_val, lat_st == ACC_HI);
    end else begin
      unique case (acc)
        ACC_HI:   rd_byte = pick_byte(live_cnt, 1'b1);
        ACC_LOHI: rd_byte = pick_byte(live_cnt, rd_upper);
        default:  rd_byte = pick_byte(live_cnt, 1'b0);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_LOHI;
      mode     <= 3'd3;
      bcd      <= 1'b0;
      wr_upper <= 1'b0;
      rd_upper <= 1'b0;
      wr_hold  <= '0;
      lat_st   <= ACC_NONE;
      lat_val  <= '0;
      sts_full <= 1'b0;
      sts_val  <= '0;
      ld_stb   <= 1'b0;
      ld_val   <= '0;
    end else begin
      ld_stb <= 1'b0;

      if (data_rd) begin
        if (sts_full) begin
          sts_full <= 1'b0;
        end else if (lat_st != ACC_NONE) begin
          lat_st <= (lat_st == ACC_LOHI) ? ACC_HI : ACC_NONE;
        end else if (acc == ACC_LOHI) begin
          rd_upper <= !rd_upper;
        end
      end

      if (data_wr) begin
        unique case (acc)
          ACC_HI: begin
            ld_stb <= 1'b1;
            ld_val <= join_bytes(wdata, '0);
          end
          ACC_LOHI: begin
            if (!wr_upper) begin
              wr_hold  <= wdata;
              wr_upper <= 1'b1;
            end else begin
              ld_stb   <= 1'b1;
              ld_val   <= join_bytes(wdata, wr_hold);
              wr_upper <= 1'b0;
            end
          end
          default: begin
            ld_stb <= 1'b1;
            ld_val <= join_bytes('0, wdata);
          end
        endcase
      end

      if (cnt_take) begin
        lat_val <= live_cnt;
        lat_st  <= acc;
      end

      if (sts_take) begin
        sts_full <= 1'b1;
        sts_val  <= status_byte(out_lvl, acc, mode, bcd);
      end

      if (ctl_set) begin
        acc      <= acc_e'(wdata[5:4]);
        mode     <= wdata[3:1];
        bcd      <= wdata[0];
        wr_upper <= 1'b0;
        rd_upper <= 1'b0;
      end
    end
  end

  // R7: a held snapshot only changes once it has been read out
  p_latch_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_st != ACC_NONE && !data_rd) |=> $stable(lat_val));

  // R9: reading a latched status byte releases it
  p_sts_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_full && data_rd && !sts_req) |=> !sts_full);

  // R10: an unread status byte is not overwritten
  p_sts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_full && !data_rd) |=> (sts_full && $stable(sts_val)));

  // R4: the first byte of a low-then-high pair gives no load
  p_first_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lohi_first && !ctl_set) |=> (!ld_stb && wr_upper));

  // R11: a control word restarts both byte sequencers
  p_seq_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set |=> (!wr_upper && !rd_upper));

  // R3: the load strobe is a single-cycle pulse without a fresh write
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !data_wr) |=> !ld_stb);

endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
  import timer_regs_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  input  logic [N_CH*CNT_W-1:0]   live_cnt,
  input  logic [N_CH-1:0]         out_lvl,
  output logic [N_CH-1:0]         ld_stb,
  output logic [N_CH*CNT_W-1:0]   ld_val,
  output logic [N_CH*MODE_W-1:0]  mode_o,
  output logic [N_CH-1:0]         bcd_o
);

  logic [N_CH-1:0]   ctl_set;
  logic [N_CH-1:0]   cnt_req;
  logic [N_CH-1:0]   sts_req;
  logic [N_CH-1:0]   data_wr;
  logic [N_CH-1:0]   data_rd;
  logic [BYTE_W-1:0] chan_byte [N_CH];

  tr_cmd_decode #(.N_CH(N_CH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .ctl_set (ctl_set),
    .cnt_req (cnt_req),
    .sts_req (sts_req),
    .data_wr (data_wr),
    .data_rd (data_rd)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    tr_chan_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_set  (ctl_set[c]),
      .cnt_req  (cnt_req[c]),
      .sts_req  (sts_req[c]),
      .data_wr  (data_wr[c]),
      .data_rd  (data_rd[c]),
      .wdata    (wdata),
      .live_cnt (live_cnt[c*CNT_W +: CNT_W]),
      .out_lvl  (out_lvl[c]),
      .rd_byte  (chan_byte[c]),
      .ld_stb   (ld_stb[c]),
      .ld_val   (ld_val[c*CNT_W +: CNT_W]),
      .mode     (mode_o[c*MODE_W +: MODE_W]),
      .bcd      (bcd_o[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr == 2'(c)) rdata = chan_byte[c];
      end
    end
  end

  // R3: loads from independent channels never coincide (one write per cycle)
  p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));

  // R12: control writes leave every load strobe low in the next cycle
  p_ctl_no_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> (ld_stb == '0));

endmodule

// File: tb/tb_timer_host_regs.sv
module tb_timer_host_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt;
  logic [2:0]  out_lvl = '0;
  logic [2:0]  ld_stb;
  logic [47:0] ld_val;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;

  logic [15:0] live [3];
  assign live_cnt = {live[2], live[1], live[0]};

  int vectors = 0;
  int errs = 0;
  logic [2:0]  cap_stb;
  logic [47:0] cap_val;
  logic [7:0]  got;
  int exp_mode [3];
  int exp_bcd [3];

  always #10 clk = ~clk;

  timer_host_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
    .ld_stb(ld_stb), .ld_val(ld_val), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    cap_stb = ld_stb;
    cap_val = ld_val;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 got = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_modes(input string tag);
    for (int c = 0; c < 3; c++) begin
      chk(tag, {45'd0, mode_o[c*3 +: 3]}, 48'(exp_mode[c]));
      chk(tag, {47'd0, bcd_o[c]}, 48'(exp_bcd[c]));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin : main
    logic [7:0] bytes [6];
    bytes = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5};
    live[0] = 16'h1234; live[1] = 16'h5678; live[2] = 16'h9ABC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < 3; c++) begin exp_mode[c] = 3; exp_bcd[c] = 0; end
    chk_modes("R1 reset mode/bcd");
    chk("R1 no strobe", {45'd0, ld_stb}, 48'd0);
    rd(0); chk("R1 first read low", {40'd0, got}, 48'h34);
    rd(0); chk("R1 second read high", {40'd0, got}, 48'h12);

    // R2/R9/R5/R3/R4 sweep
    for (int c = 0; c < 3; c++) begin
      for (int a = 1; a < 4; a++) begin
        for (int m = 0; m < 8; m++) begin
          for (int b = 0; b < 2; b++) begin
            logic [15:0] lv;
            logic ol;
            lv = 16'h1000 * 16'(c + 1) + 16'(a * 16 + m * 2 + b) + 16'h0300;
            live[c] = lv;
            ol = 1'((m ^ c) & 1);
            out_lvl[c] = ol;
            wr(2'(3), {2'(c), 2'(a), 3'(m), 1'(b)});
            exp_mode[c] = m; exp_bcd[c] = b;
            chk_modes("R2/R12 control decode");
            wr(2'(3), 8'hE0 | (8'd1 << (c + 1)));
            rd(2'(c));
            chk("R9 status byte", {40'd0, got}, {40'd0, ol, 1'b0, 2'(a), 3'(m), 1'(b)});
            rd(2'(c));
            chk("R5 live read 1", {40'd0, got}, {40'd0, (a == 2) ? lv[15:8] : lv[7:0]});
            if (a == 3) begin
              rd(2'(c));
              chk("R5 live read 2", {40'd0, got}, {40'd0, lv[15:8]});
            end
            if (m == 0 && b == 0) begin
              for (int k = 0; k < 6; k++) begin
                logic [47:0] ev;
                ev = '0;
                if (a == 1) begin
                  wr(2'(c), bytes[k]);
                  ev[c*16 +: 16] = {8'h00, bytes[k]};
                  chk("R3 low-only strobe", {45'd0, cap_stb}, {45'd0, 3'(1 << c)});
                  chk("R3 low-only value", cap_val & (48'hFFFF << (c*16)), ev);
                end else if (a == 2) begin
                  wr(2'(c), bytes[k]);
                  ev[c*16 +: 16] = {bytes[k], 8'h00};
                  chk("R3 high-only strobe", {45'd0, cap_stb}, {45'd0, 3'(1 << c)});
                  chk("R3 high-only value", cap_val & (48'hFFFF << (c*16)), ev);
                end else begin
                  wr(2'(c), bytes[k]);
                  chk("R4 first byte no strobe", {45'd0, cap_stb}, 48'd0);
                  wr(2'(c), bytes[k] ^ 8'h5A);
                  ev[c*16 +: 16] = {bytes[k] ^ 8'h5A, bytes[k]};
                  chk("R4 pair strobe", {45'd0, cap_stb}, {45'd0, 3'(1 << c)});
                  chk("R4 pair value", cap_val & (48'hFFFF << (c*16)), ev);
                end
              end
            end
          end
        end
      end
    end

    // R6/R7: latch in low-then-high access, second latch ignored
    wr(3, 8'h74); live[1] = 16'hBEEF;
    wr(3, 8'h40); live[1] = 16'h0000;
    wr(3, 8'h40); live[1] = 16'h1357;
    rd(1); chk("R6/R7 latched low", {40'd0, got}, 48'hEF);
    rd(1); chk("R6/R7 latched high", {40'd0, got}, 48'hBE);
    rd(1); chk("R6 back to live low", {40'd0, got}, 48'h57);
    rd(1); chk("R6 back to live high", {40'd0, got}, 48'h13);
    // low-only latch: one byte
    wr(3, 8'h90); live[2] = 16'hC3D4;
    wr(3, 8'h80); live[2] = 16'h4455;
    rd(2); chk("R6 low-only latched", {40'd0, got}, 48'hD4);
    rd(2); chk("R6 low-only live after", {40'd0, got}, 48'h55);
    // high-only latch
    wr(3, 8'h20); live[0] = 16'h9A8B;
    wr(3, 8'h00); live[0] = 16'h6677;
    rd(0); chk("R6 high-only latched", {40'd0, got}, 48'h9A);
    rd(0); chk("R6 high-only live after", {40'd0, got}, 48'h66);

    // R8: readback count latch for channels 0 and 2 only
    wr(3, 8'h30); wr(3, 8'h70); wr(3, 8'hB0);
    live[0] = 16'hA0A1; live[1] = 16'hB0B1; live[2] = 16'hC0C1;
    wr(3, 8'hDA);
    live[0] = 16'h0102; live[1] = 16'h0304; live[2] = 16'h0506;
    rd(0); chk("R8 ch0 latched low", {40'd0, got}, 48'hA1);
    rd(0); chk("R8 ch0 latched high", {40'd0, got}, 48'hA0);
    rd(1); chk("R8 ch1 unselected live", {40'd0, got}, 48'h04);
    rd(1); chk("R8 ch1 unselected live high", {40'd0, got}, 48'h03);
    rd(2); chk("R8 ch2 latched low", {40'd0, got}, 48'hC1);
    rd(2); chk("R8 ch2 latched high", {40'd0, got}, 48'hC0);

    // R8/R9: status and count together, status read first
    out_lvl[1] = 1'b1; live[1] = 16'hDEAD;
    wr(3, 8'hC4);
    live[1] = 16'h0000;
    rd(1); chk("R9 status before count", {40'd0, got}, 48'hB0);
    rd(1); chk("R9 then latched low", {40'd0, got}, 48'hAD);
    rd(1); chk("R9 then latched high", {40'd0, got}, 48'hDE);

    // R10: second status request ignored
    live[1] = 16'h2468;
    wr(3, 8'hE4);
    out_lvl[1] = 1'b0;
    wr(3, 8'hE4);
    rd(1); chk("R10 first status kept", {40'd0, got}, 48'hB0);
    rd(1); chk("R10 no second status", {40'd0, got}, 48'h68);

    // R11: control word resets write and read sequencers
    wr(3, 8'h30);
    wr(0, 8'h11); chk("R11 held first byte", {45'd0, cap_stb}, 48'd0);
    wr(3, 8'h30);
    wr(0, 8'h22); chk("R11 restart no strobe", {45'd0, cap_stb}, 48'd0);
    wr(0, 8'h33); chk("R11 restart value", cap_val & 48'hFFFF, 48'h3322);
    live[0] = 16'h7788;
    rd(0); chk("R11 read low", {40'd0, got}, 48'h88);
    wr(3, 8'h30);
    rd(0); chk("R11 read restarts low", {40'd0, got}, 48'h88);

    // R12: address 3 reads 0; other channels untouched
    rd(3); chk("R12 addr3 reads zero", {40'd0, got}, 48'd0);
    wr(0, 8'h44);
    wr(1, 8'h99); chk("R12 ch1 write own seq", {45'd0, cap_stb}, 48'd0);
    wr(2, 8'h01); chk("R12 ch2 write own seq", {45'd0, cap_stb}, 48'd0);
    wr(0, 8'h55);
    chk("R12 ch0 pair unaffected", {45'd0, cap_stb}, 48'd1);
    chk("R12 ch0 value", cap_val & 48'hFFFF, 48'h5544);
    exp_mode[0] = 0; exp_bcd[0] = 0; exp_mode[1] = 0; exp_bcd[1] = 0;
    exp_mode[2] = 0; exp_bcd[2] = 0;
    chk_modes("R12 settings unaffected");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule